// File: doc/BRIEF.md
# Fully-Decoded I/O Port Decoder

This block sits on the I/O side of an 8-bit CPU system. It watches the CPU's I/O cycles (IORQ with RD or WR, all active low) and compares each port address with a fixed set of exact addresses. Partial decoding is not used: a port that does not match exactly reads as an open bus.

Three functions share the decoder. The first is the basic I/O port. Writing it sets the border colour, the tape MIC line and the beeper. Reading it returns one or more half-rows of a 40-key matrix, and the half-rows are picked by the upper address byte. The second is a shadow of a 15-register sound-chip register file. It can be reached through two separate port sets, and one register drives a bit-banged I2C clock and data pair as open-drain lines. The third is a control port, whose last written value is read back.

A write takes effect once per I/O cycle, at the first clock edge on which the write strobe is seen. Read data is combinational and follows the address and strobes.

Top module: `io_port_decoder`

## Requirements
- R1: After reset the border is 0, MIC and beeper are 0, the sound register select is 0, sound registers 0–13 and the control port hold 0x00, and register 14 holds 0xFF, so both I2C lines are released.
- R2: A write whose low address byte is 0xFE, with any high byte, loads the border from data bits 2:0, MIC from bit 3 and the beeper from bit 4. Writes to any other address leave these outputs unchanged.
- R3: A read with low address byte 0xFE returns key data in bits 4:0 and 1s in bits 7:5. Key index r*5+b (keys input bit, 1 = pressed) is half-row r, column b. It appears as 0 in data bit b when address bit 8+r is 0. Several selected half-rows combine, so a key pressed in any of them reads 0.
- R4: A write to address 0xFFFD, or to low address byte 0xF5, selects sound register 0–14. A value of 15 or more leaves the selection unchanged.
- R5: A write to address 0xBFFD, or to low address byte 0xF6, stores the data in the selected register. A read of 0xFFFD, or of low address byte 0xF5, returns the selected register. Both port sets reach the same registers.
- R6: Register 14 bit 0 controls SDA and bit 1 controls SCL. A 0 bit pulls the line low (pull output 1). A 1 bit releases the line (pull output 0).
- R7: A read with low address byte 0xFF returns the last byte written to that port.
- R8: A read of any other address returns 0xFF, and so does the read data bus whenever no read cycle is active. This includes 0xBFFD, 0x7FFD and 0xFFFC.
- R9: While the write strobe stays active, only the data present at its first clock edge is written. Later changes to the data bus within the same cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | CPU port address |
| wdata | input | 8 | CPU data bus towards the block |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| keys | input | 40 | Key matrix state, 1 = pressed, index row*5+column |
| rdata | output | 8 | Read data, 0xFF when not driven by a port |
| border | output | 3 | Border colour |
| mic | output | 1 | Tape MIC output |
| beeper | output | 1 | Beeper output |
| sda_pull | output | 1 | 1 = pull I2C data low |
| scl_pull | output | 1 | 1 = pull I2C clock low |

## Verification
The bench probes addresses that differ from a decoded port by only one bit or only in the high byte, such as 0xFFFC, 0x7FFD and 0xBFFD read back, and 0x12FE written. A decoder that checks too few address bits would then answer or latch on those addresses. It also sends register selects of 15 and 255, and a design that accepts them would put the following data write and read on a wrong or missing register. Keyboard reads with two half-rows selected, and with none selected, expose a design that picks a single row or inverts the sense of the data. Holding a write strobe while the data changes reveals a level-sensitive write. A reference model is compared against the outputs on every clock, so a swapped SDA/SCL bit or an inverted pull also shows up.

// File: rtl/iodec_pkg.sv
package iodec_pkg;

   // Exact decode helpers
   function automatic logic lo_hit(input logic [15:0] a, input logic [7:0] lo);
      return a[7:0] == lo;
   endfunction

   function automatic logic full_hit(input logic [15:0] a, input logic [15:0] full);
      return a == full;
   endfunction

   typedef struct packed {
      logic [2:0] border;
      logic       mic;
      logic       beep;
   } ula_out_t;

endpackage

// File: rtl/iodec_strobe.sv
module iodec_strobe (
   input  logic clk,
   input  logic rst_n,
   input  logic iorq_n,
   input  logic rd_n,
   input  logic wr_n,
   output logic wr_pulse,
   output logic rd_on
);
   logic wr_on;
   logic wr_seen;

   assign wr_on    = !iorq_n && !wr_n;
   assign rd_on    = !iorq_n && !rd_n;
   assign wr_pulse = wr_on && !wr_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_seen <= 1'b0;
      else        wr_seen <= wr_on;
   end

   // R9: one write pulse per strobe assertion
   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pulse |=> !wr_pulse);
endmodule

// File: rtl/iodec_ula.sv
module iodec_ula
   import iodec_pkg::*;
#(
   parameter int DW       = 8,
   parameter int AW       = 16,
   parameter int KEY_ROWS = 8,
   parameter int KEY_COLS = 5
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         we,
   input  logic [AW-1:0]                addr,
   input  logic [DW-1:0]                wdata,
   input  logic [KEY_ROWS*KEY_COLS-1:0] keys,
   output logic [DW-1:0]                kbd_data,
   output ula_out_t                     outs
);
   localparam int ROW_BASE = AW - KEY_ROWS;

   generate
      if (KEY_COLS > DW) begin : g_bad_cols
         $error("iodec_ula: KEY_COLS wider than data bus");
      end
      if (KEY_COLS < 5 || DW < 5) begin : g_bad_fields
         $error("iodec_ula: output fields need at least 5 data bits");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         outs <= '0;
      end else if (we) begin
         outs.border <= wdata[2:0];
         outs.mic    <= wdata[3];
         outs.beep   <= wdata[4];
      end
   end

   logic [KEY_COLS-1:0] col_down;

   always_comb begin
      col_down = '0;
      for (int r = 0; r < KEY_ROWS; r++) begin
         if (!addr[ROW_BASE+r]) begin
            for (int c = 0; c < KEY_COLS; c++) begin
               col_down[c] = col_down[c] | keys[r*KEY_COLS+c];
            end
         end
      end
   end

   generate
      if (DW > KEY_COLS) begin : g_pad
         assign kbd_data = {{(DW-KEY_COLS){1'b1}}, ~col_down};
      end else begin : g_nopad
         assign kbd_data = ~col_down;
      end
   endgenerate

   // R2: outputs follow the written byte
   a_r2_border_loaded: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (outs.border == $past(wdata[2:0])) && (outs.beep == $past(wdata[4])));
   // R2/R9: without a write pulse nothing moves
   a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(outs));
endmodule

// File: rtl/iodec_snd.sv
module iodec_snd #(
   parameter int DW       = 8,
   parameter int NREG     = 15,
   parameter int I2C_REG  = 14,
   parameter int SDA_BIT  = 0,
   parameter int SCL_BIT  = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel_we,
   input  logic          dat_we,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rd_val,
   output logic          sda_pull,
   output logic          scl_pull
);
   localparam int            SELW   = (NREG > 1) ? $clog2(NREG) : 1;
   localparam logic [DW-1:0] NREG_V = DW'(NREG);

   generate
      if (I2C_REG >= NREG) begin : g_bad_i2c
         $error("iodec_snd: I2C register outside the file");
      end
      if (SDA_BIT == SCL_BIT || SDA_BIT >= DW || SCL_BIT >= DW) begin : g_bad_bits
         $error("iodec_snd: bad I2C bit positions");
      end
      if (NREG > (1 << DW)) begin : g_bad_nreg
         $error("iodec_snd: register count exceeds select range");
      end
   endgenerate

   logic [DW-1:0]   regs [NREG];
   logic [SELW-1:0] sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel <= '0;
      end else if (sel_we && (wdata < NREG_V)) begin
         sel <= wdata[SELW-1:0];
      end
   end

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs[i] <= (i == I2C_REG) ? '1 : '0;
         end else if (dat_we && (sel == SELW'(i))) begin
            regs[i] <= wdata;
         end
      end
   end

   assign rd_val   = regs[sel];
   assign sda_pull = !regs[I2C_REG][SDA_BIT];
   assign scl_pull = !regs[I2C_REG][SCL_BIT];

   // R4: selection never leaves the file
   a_r4_sel_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      sel < SELW'(NREG));
   // R4: out-of-range selects are dropped
   a_r4_big_sel_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_we && wdata >= NREG_V) |=> $stable(sel));
   // R5: data write lands in the register then selected
   a_r5_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_we && !sel_we) |=> rd_val == $past(wdata));
   // R6: I2C pins only move on a write
   a_r6_i2c_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !dat_we |=> $stable({sda_pull, scl_pull}));
endmodule

// File: rtl/iodec_latch.sv
module iodec_latch #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata;
   end

   // R7: latch keeps its value between writes
   a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));
endmodule

// File: rtl/io_port_decoder.sv
module io_port_decoder
   import iodec_pkg::*;
#(
   parameter int          DW          = 8,
   parameter int          AW          = 16,
   parameter int          KEY_ROWS    = 8,
   parameter int          KEY_COLS    = 5,
   parameter int          NREG        = 15,
   parameter int          I2C_REG     = 14,
   parameter logic [7:0]  BASIC_LO    = 8'hFE,
   parameter logic [7:0]  CTRL_LO     = 8'hFF,
   parameter logic [15:0] SEL_FULL    = 16'hFFFD,
   parameter logic [15:0] DAT_FULL    = 16'hBFFD,
   parameter logic [7:0]  SEL_LO_ALT  = 8'hF5,
   parameter logic [7:0]  DAT_LO_ALT  = 8'hF6
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [AW-1:0]                addr,
   input  logic [DW-1:0]                wdata,
   input  logic                         iorq_n,
   input  logic                         rd_n,
   input  logic                         wr_n,
   input  logic [KEY_ROWS*KEY_COLS-1:0] keys,
   output logic [DW-1:0]                rdata,
   output logic [2:0]                   border,
   output logic                         mic,
   output logic                         beeper,
   output logic                         sda_pull,
   output logic                         scl_pull
);
   generate
      if (AW != 16 || KEY_ROWS != 8) begin : g_bad_bus
         $error("io_port_decoder: row select needs a 16-bit bus and 8 rows");
      end
   endgenerate

   logic wr_pulse, rd_on;

   iodec_strobe i_strobe (
      .clk      (clk),
      .rst_n    (rst_n),
      .iorq_n   (iorq_n),
      .rd_n     (rd_n),
      .wr_n     (wr_n),
      .wr_pulse (wr_pulse),
      .rd_on    (rd_on)
   );

   logic hit_basic, hit_ctrl, hit_sel, hit_dat;

   assign hit_basic = lo_hit(addr, BASIC_LO);
   assign hit_ctrl  = lo_hit(addr, CTRL_LO);
   assign hit_sel   = full_hit(addr, SEL_FULL) || lo_hit(addr, SEL_LO_ALT);
   assign hit_dat   = full_hit(addr, DAT_FULL) || lo_hit(addr, DAT_LO_ALT);

   logic [DW-1:0] kbd_data, snd_val, ctrl_q;
   ula_out_t      ula_q;

   iodec_ula #(
      .DW       (DW),
      .AW       (AW),
      .KEY_ROWS (KEY_ROWS),
      .KEY_COLS (KEY_COLS)
   ) i_ula (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (wr_pulse && hit_basic),
      .addr     (addr),
      .wdata    (wdata),
      .keys     (keys),
      .kbd_data (kbd_data),
      .outs     (ula_q)
   );

   iodec_snd #(
      .DW      (DW),
      .NREG    (NREG),
      .I2C_REG (I2C_REG)
   ) i_snd (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_we   (wr_pulse && hit_sel),
      .dat_we   (wr_pulse && hit_dat),
      .wdata    (wdata),
      .rd_val   (snd_val),
      .sda_pull (sda_pull),
      .scl_pull (scl_pull)
   );

   iodec_latch #(.DW(DW)) i_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_pulse && hit_ctrl),
      .wdata (wdata),
      .q     (ctrl_q)
   );

   assign border = ula_q.border;
   assign mic    = ula_q.mic;
   assign beeper = ula_q.beep;

   always_comb begin
      rdata = '1;
      if (rd_on) begin
         if (hit_basic)     rdata = kbd_data;
         else if (hit_sel)  rdata = snd_val;
         else if (hit_ctrl) rdata = ctrl_q;
      end
   end

   // R8: bus floats high outside read cycles
   a_r8_float_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_on |-> rdata == '1);
   // R3: keyboard reads keep the unused upper bits high
   a_r3_upper_bits_high: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_on && hit_basic) |-> rdata[DW-1:KEY_COLS] == '1);
endmodule

// File: tb/test_io_port_decoder.sv
module test_io_port_decoder;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = 16'h0000;
   logic [7:0]  wdata = 8'h00;
   logic        iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [39:0] keys = '0;
   logic [7:0]  rdata;
   logic [2:0]  border;
   logic        mic, beeper, sda_pull, scl_pull;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference model state
   int m_border = 0, m_mic = 0, m_beep = 0, m_sel = 0, m_ctrl = 0;
   int m_regs[15];

   always #(CLK_PERIOD/2) clk = ~clk;

   io_port_decoder i_io_port_decoder (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
      .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .keys(keys),
      .rdata(rdata), .border(border), .mic(mic), .beeper(beeper),
      .sda_pull(sda_pull), .scl_pull(scl_pull)
   );

   task automatic chk(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_border = 0; m_mic = 0; m_beep = 0; m_sel = 0; m_ctrl = 0;
      foreach (m_regs[i]) m_regs[i] = (i == 14) ? 255 : 0;
   endtask

   task automatic model_write(input logic [15:0] a, input logic [7:0] d);
      if (a[7:0] == 8'hFE) begin
         m_border = d & 7; m_mic = d[3]; m_beep = d[4];
      end
      if ((a == 16'hFFFD || a[7:0] == 8'hF5) && d < 15) m_sel = d;
      if (a == 16'hBFFD || a[7:0] == 8'hF6) m_regs[m_sel] = d;
      if (a[7:0] == 8'hFF) m_ctrl = d;
   endtask

   function automatic int exp_read(input logic [15:0] a, input bit active);
      int v;
      if (!active) return 255;
      if (a[7:0] == 8'hFE) begin
         v = 255;
         for (int r = 0; r < 8; r++)
            if (!a[8+r])
               for (int b = 0; b < 5; b++)
                  if (keys[r*5+b]) v = v & ~(1 << b);
         return v;
      end
      if (a == 16'hFFFD || a[7:0] == 8'hF5) return m_regs[m_sel];
      if (a[7:0] == 8'hFF) return m_ctrl;
      return 255;
   endfunction

   function automatic string tag_for(input logic [15:0] a);
      if (a[7:0] == 8'hFE) return "R3";
      if (a == 16'hFFFD || a[7:0] == 8'hF5) return "R5";
      if (a[7:0] == 8'hFF) return "R7";
      return "R8";
   endfunction

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (!done) begin
         string t;
         t = rst_n ? "R2" : "R1";
         chk({t, " border"}, border, m_border);
         chk({t, " mic/beeper"}, {mic, beeper}, {m_mic[0], m_beep[0]});
         chk(rst_n ? "R6 pulls" : "R1 pulls", {sda_pull, scl_pull},
             {~m_regs[14][0], ~m_regs[14][1]});
         chk(tag_for(addr), rdata, exp_read(addr, !iorq_n && !rd_n));
      end
   end

   task automatic io_write(input logic [15:0] a, input logic [7:0] d,
                           input bit change_mid = 0);
      @(negedge clk);
      addr = a; wdata = d; iorq_n = 1'b0; wr_n = 1'b0;
      @(posedge clk);
      #1 model_write(a, d);
      if (change_mid) wdata = ~d;   // R9: late data must be ignored
      @(posedge clk);
      @(negedge clk);
      iorq_n = 1'b1; wr_n = 1'b1;
   endtask

   task automatic io_read(input logic [15:0] a, input string tag, input int exp);
      @(negedge clk);
      addr = a; iorq_n = 1'b0; rd_n = 1'b0;
      #1 chk(tag, rdata, exp);
      @(negedge clk);
      iorq_n = 1'b1; rd_n = 1'b1;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++; checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1: reset state seen through the ports
      chk("R1 border", border, 0);
      chk("R1 sda/scl released", {sda_pull, scl_pull}, 0);
      io_read(16'h00FF, "R1 ctrl", 0);
      io_read(16'hFFFD, "R1 sel reg0", 0);

      // R2: basic port writes, high byte ignored, near misses ignored
      io_write(16'h00FE, 8'h1D);
      chk("R2 border 5", border, 5);
      chk("R2 mic/beep", {mic, beeper}, 2'b11);
      io_write(16'h12FE, 8'h02);
      chk("R2 high byte don't care", border, 2);
      io_write(16'h00FC, 8'h1F);
      chk("R2 near miss ignored", border, 2);
      io_write(16'hFEFF, 8'h07);
      chk("R2 ctrl port not basic", border, 2);

      // R9: data changing mid-strobe
      io_write(16'h00FE, 8'h04, 1);
      chk("R9 first data kept", border, 4);
      chk("R9 mic stays low", mic, 0);

      // R3: keyboard
      keys = '0;
      keys[0] = 1'b1; keys[4] = 1'b1;      // row 0 cols 0,4
      keys[7*5+2] = 1'b1;                  // row 7 col 2
      keys[1*5+1] = 1'b1;                  // row 1 col 1
      io_read(16'hFEFE, "R3 row0", 8'hEE);
      io_read(16'h7FFE, "R3 row7", 8'hFB);
      io_read(16'h7EFE, "R3 rows 0+7", 8'hEA);
      io_read(16'hFCFE, "R3 rows 0+1", 8'hEC);
      io_read(16'hFFFE, "R3 no row", 8'hFF);
      io_read(16'h00FE, "R3 all rows", 8'hE8);

      // R4/R5: both port sets
      io_write(16'hFFFD, 8'h03);
      io_write(16'hBFFD, 8'hA5);
      io_read(16'hFFFD, "R5 reg3 via full", 8'hA5);
      io_read(16'h00F5, "R5 reg3 via alt", 8'hA5);
      io_write(16'h00F5, 8'h07);
      io_write(16'h33F6, 8'h3C);
      io_read(16'hFFFD, "R5 reg7 cross port", 8'h3C);
      io_write(16'hFFFD, 8'h0F);
      io_read(16'h00F5, "R4 select 15 ignored", 8'h3C);
      io_write(16'h00F5, 8'hFF);
      io_read(16'hFFFD, "R4 select 255 ignored", 8'h3C);
      io_write(16'hBFFD, 8'h11);
      io_write(16'hFFFD, 8'h03);
      io_read(16'hFFFD, "R5 reg3 untouched", 8'hA5);

      // R6: I2C through register 14
      io_write(16'hFFFD, 8'h0E);
      io_write(16'hBFFD, 8'hFE);
      chk("R6 sda pulled", {sda_pull, scl_pull}, 2'b10);
      io_write(16'h00F6, 8'hFD);
      chk("R6 scl pulled", {sda_pull, scl_pull}, 2'b01);
      io_write(16'hBFFD, 8'h00);
      chk("R6 both pulled", {sda_pull, scl_pull}, 2'b11);
      io_write(16'hBFFD, 8'hFF);
      chk("R6 both released", {sda_pull, scl_pull}, 2'b00);

      // R7: control latch
      io_write(16'h00FF, 8'h5A);
      io_read(16'h00FF, "R7 readback", 8'h5A);
      io_read(16'h12FF, "R7 high byte don't care", 8'h5A);

      // R8: undecoded reads
      io_read(16'hBFFD, "R8 data port not readable", 8'hFF);
      io_read(16'h7FFD, "R8 0x7FFD", 8'hFF);
      io_read(16'hFFFC, "R8 0xFFFC", 8'hFF);
      io_read(16'h00F6, "R8 0xF6", 8'hFF);
      io_write(16'h7FFD, 8'h00);
      io_read(16'h00FF, "R8 undecoded write ignored", 8'h5A);
      @(negedge clk);
      addr = 16'h00FF;
      #1 chk("R8 idle bus", rdata, 8'hFF);

      repeat (2) @(negedge clk);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule